// File: doc/BRIEF.md
# UART FIFO Trigger and Interrupt Control

This block is the FIFO front end of a UART. It has one first-in first-out buffer for the transmitter and one for the receiver. The host programs it through an 8-bit control register and a 2-bit trigger-table register, both written over a small address/data port. The control register turns FIFO mode on and off. It also flushes either buffer and picks a threshold code for each direction. The table register chooses which of four threshold tables those codes index. Three of the tables are fixed. The fourth takes its levels from two plain input buses.

The serializer and deserializer sit outside the block and talk to it through push and pop strobes. Each side exposes its fill level and a sticky overrun flag. The receive interrupt request is raised once the receive buffer holds at least its threshold. The transmit interrupt request follows a refill-aware rule. If the buffer was loaded past its threshold, the request fires when the level falls below that threshold. Otherwise it fires only when the buffer runs empty. With FIFO mode off, each side shrinks to a single holding slot and both thresholds become 1.

Top module: `uart_fifo_trig_ctrl`

## Requirements
- R1: After reset, the control register (address 0) and the table register (address 1) read 0, both levels are 0, the transmit request is 1 and the receive request is 0.
- R2: A write to address 0 always stores bit 0 (FIFO enable). Bits 3 (DMA mode, stored with no effect), 5:4 (transmit code) and 7:6 (receive code) change only when bit 0 of the same write is 1. Bits 2:1 always read back as 0.
- R3: A control write with bits 0 and 1 both set empties the receive buffer and clears its overrun flag at that clock edge, and leaves the transmit side unchanged. With bit 0 clear, bit 1 has no effect.
- R4: A control write with bits 0 and 2 both set empties the transmit buffer and clears its overrun flag, and leaves the receive side unchanged.
- R5: A control write whose bit 0 differs from the stored enable empties both buffers and clears both overrun flags.
- R6: In FIFO mode each buffer holds up to DEPTH (64) entries and returns them in push order. Read data is valid on the cycle after the pop edge.
- R7: A push into a full buffer without a simultaneous pop is dropped and sets that side's overrun flag, which stays set until a flush. A pop of an empty buffer leaves the level and the read data unchanged.
- R8: With FIFO mode off, each buffer holds one entry and both thresholds are 1, whatever the stored codes are.
- R9: Receive thresholds for codes 0..3 are: table 0 gives 1, 4, 8, 14; table 1 gives 8, 16, 24, 28; table 2 gives 8, 16, 56, 60.
- R10: Transmit thresholds for codes 0..3 are: table 0 gives 1 for every code; table 1 gives 16, 8, 24, 30; table 2 gives 8, 16, 32, 56.
- R11: Table 3 takes the receive and transmit thresholds from rx_prog_lvl and tx_prog_lvl. A programmed value of 0 acts as 1.
- R12: rx_irq is 1 exactly when the receive level is at least the receive threshold.
- R13: If the transmit level has exceeded the transmit threshold since the buffer was last empty, tx_irq is 1 when the level is below the threshold. Otherwise tx_irq is 1 only at level 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 selects the control register, 1 selects the table register |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data of the addressed register |
| rx_prog_lvl | input | LW | Receive threshold used with table 3 |
| tx_prog_lvl | input | LW | Transmit threshold used with table 3 |
| tx_push | input | 1 | Host writes one byte to the transmit buffer |
| tx_wdata | input | DW | Transmit byte to store |
| tx_pop | input | 1 | Serializer takes one byte |
| tx_rdata | output | DW | Byte taken by the last transmit pop |
| tx_level | output | LW | Transmit fill level |
| tx_ovr | output | 1 | Sticky transmit overrun |
| tx_irq | output | 1 | Transmit-ready interrupt request |
| rx_push | input | 1 | Deserializer delivers one byte |
| rx_wdata | input | DW | Received byte to store |
| rx_pop | input | 1 | Host reads one byte |
| rx_rdata | output | DW | Byte taken by the last receive pop |
| rx_level | output | LW | Receive fill level |
| rx_ovr | output | 1 | Sticky receive overrun |
| rx_irq | output | 1 | Receive-ready interrupt request |

## Verification
Threshold decoding is probed by filling a buffer to one entry short of the expected level and then to the level itself. That separates a correct table entry from its neighbours in the same table and from the same code in another table. The transmit request is exercised twice at the same threshold: once after a fill past the threshold and once after a fill that stops exactly at it. This tells the refill-aware rule apart from a plain level compare. A full-depth fill and drain with distinct data checks ordering, the dropped push and the empty pop. Writes with the enable bit clear check that gated bits and flush requests are ignored and that single-slot mode holds.

// File: rtl/uft_pkg.sv
package uft_pkg;

  typedef enum logic [1:0] {
    TBL_A = 2'd0,
    TBL_B = 2'd1,
    TBL_C = 2'd2,
    TBL_D = 2'd3
  } trig_tbl_e;

  typedef struct packed {
    logic [1:0] rx_sel;
    logic [1:0] tx_sel;
    logic       dma;
    logic       en;
  } fcr_cfg_t;

  function automatic logic [7:0] rx_lut(trig_tbl_e t, logic [1:0] c);
    logic [7:0] v;
    v = 8'd1;
    case (t)
      TBL_A: case (c)
        2'd0: v = 8'd1;
        2'd1: v = 8'd4;
        2'd2: v = 8'd8;
        default: v = 8'd14;
      endcase
      TBL_B: case (c)
        2'd0: v = 8'd8;
        2'd1: v = 8'd16;
        2'd2: v = 8'd24;
        default: v = 8'd28;
      endcase
      TBL_C: case (c)
        2'd0: v = 8'd8;
        2'd1: v = 8'd16;
        2'd2: v = 8'd56;
        default: v = 8'd60;
      endcase
      default: v = 8'd1;
    endcase
    return v;
  endfunction

  function automatic logic [7:0] tx_lut(trig_tbl_e t, logic [1:0] c);
    logic [7:0] v;
    v = 8'd1;
    case (t)
      TBL_B: case (c)
        2'd0: v = 8'd16;
        2'd1: v = 8'd8;
        2'd2: v = 8'd24;
        default: v = 8'd30;
      endcase
      TBL_C: case (c)
        2'd0: v = 8'd8;
        2'd1: v = 8'd16;
        2'd2: v = 8'd32;
        default: v = 8'd56;
      endcase
      default: v = 8'd1;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/uft_fcr_regs.sv
module uft_fcr_regs
  import uft_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr,
  input  logic       addr,
  input  logic [7:0] wdata,
  output fcr_cfg_t   cfg,
  output trig_tbl_e  tbl,
  output logic       rx_flush,
  output logic       tx_flush,
  output logic [7:0] rdata
);

  logic ctl_sel;
  logic en_chg;

  assign ctl_sel  = wr & ~addr;
  assign en_chg   = ctl_sel & (wdata[0] != cfg.en);
  assign rx_flush = en_chg | (ctl_sel & wdata[0] & wdata[1]);
  assign tx_flush = en_chg | (ctl_sel & wdata[0] & wdata[2]);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg <= '0;
      tbl <= TBL_A;
    end else begin
      if (ctl_sel) begin
        cfg.en <= wdata[0];
        if (wdata[0]) begin
          cfg.dma    <= wdata[3];
          cfg.tx_sel <= wdata[5:4];
          cfg.rx_sel <= wdata[7:6];
        end
      end
      if (wr && addr) tbl <= trig_tbl_e'(wdata[1:0]);
    end
  end

  always_comb begin
    if (addr) rdata = {6'b0, tbl};
    else      rdata = {cfg.rx_sel, cfg.tx_sel, cfg.dma, 2'b00, cfg.en};
  end

endmodule

// File: rtl/uft_trig.sv
module uft_trig
  import uft_pkg::*;
#(
  parameter int LW = 7
) (
  input  logic          en,
  input  trig_tbl_e     tbl,
  input  logic [1:0]    rx_sel,
  input  logic [1:0]    tx_sel,
  input  logic [LW-1:0] rx_prog,
  input  logic [LW-1:0] tx_prog,
  output logic [LW-1:0] rx_trig,
  output logic [LW-1:0] tx_trig
);

  localparam logic [LW-1:0] ONE = LW'(1);

  logic [7:0] rx_fix, tx_fix;

  assign rx_fix = rx_lut(tbl, rx_sel);
  assign tx_fix = tx_lut(tbl, tx_sel);

  always_comb begin
    if (!en) begin
      rx_trig = ONE;
      tx_trig = ONE;
    end else if (tbl == TBL_D) begin
      rx_trig = (rx_prog == '0) ? ONE : rx_prog;
      tx_trig = (tx_prog == '0) ? ONE : tx_prog;
    end else begin
      rx_trig = LW'(rx_fix);
      tx_trig = LW'(tx_fix);
    end
  end

endmodule

// File: rtl/uft_fifo.sv
module uft_fifo #(
  parameter int DEPTH = 64,
  parameter int DW    = 8,
  parameter int LW    = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          single,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  output logic [DW-1:0] rdata,
  output logic [LW-1:0] level,
  output logic          ovr
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          full, empty, pop_ok, push_ok;
  logic [LW-1:0] cap;

  assign cap     = single ? LW'(1) : LW'(DEPTH);
  assign full    = (level == cap);
  assign empty   = (level == '0);
  assign pop_ok  = pop & ~empty;
  assign push_ok = push & (~full | pop_ok);

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
      ovr    <= 1'b0;
      rdata  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
      ovr    <= 1'b0;
    end else begin
      if (push_ok) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (pop_ok) begin
        rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
        rdata  <= mem[rd_ptr];
      end
      if (push_ok && !pop_ok)      level <= level + 1'b1;
      else if (pop_ok && !push_ok) level <= level - 1'b1;
      if (push && !push_ok) ovr <= 1'b1;
    end
  end

endmodule

// File: rtl/uart_fifo_trig_ctrl.sv
module uart_fifo_trig_ctrl
  import uft_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int DW    = 8,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_wr,
  input  logic          reg_addr,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  input  logic [LW-1:0] rx_prog_lvl,
  input  logic [LW-1:0] tx_prog_lvl,
  input  logic          tx_push,
  input  logic [DW-1:0] tx_wdata,
  input  logic          tx_pop,
  output logic [DW-1:0] tx_rdata,
  output logic [LW-1:0] tx_level,
  output logic          tx_ovr,
  output logic          tx_irq,
  input  logic          rx_push,
  input  logic [DW-1:0] rx_wdata,
  input  logic          rx_pop,
  output logic [DW-1:0] rx_rdata,
  output logic [LW-1:0] rx_level,
  output logic          rx_ovr,
  output logic          rx_irq
);

  fcr_cfg_t      cfg;
  trig_tbl_e     tbl;
  logic          rx_flush, tx_flush;
  logic          fifo_en;
  logic [LW-1:0] rx_trig, tx_trig;
  logic          tx_armed;

  assign fifo_en = cfg.en;

  uft_fcr_regs u_regs (
    .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .cfg(cfg), .tbl(tbl), .rx_flush(rx_flush), .tx_flush(tx_flush),
    .rdata(reg_rdata)
  );

  uft_trig #(.LW(LW)) u_trig (
    .en(cfg.en), .tbl(tbl), .rx_sel(cfg.rx_sel), .tx_sel(cfg.tx_sel),
    .rx_prog(rx_prog_lvl), .tx_prog(tx_prog_lvl),
    .rx_trig(rx_trig), .tx_trig(tx_trig)
  );

  uft_fifo #(.DEPTH(DEPTH), .DW(DW), .LW(LW)) u_txf (
    .clk(clk), .rst(rst), .flush(tx_flush), .single(~cfg.en),
    .push(tx_push), .wdata(tx_wdata), .pop(tx_pop),
    .rdata(tx_rdata), .level(tx_level), .ovr(tx_ovr)
  );

  uft_fifo #(.DEPTH(DEPTH), .DW(DW), .LW(LW)) u_rxf (
    .clk(clk), .rst(rst), .flush(rx_flush), .single(~cfg.en),
    .push(rx_push), .wdata(rx_wdata), .pop(rx_pop),
    .rdata(rx_rdata), .level(rx_level), .ovr(rx_ovr)
  );

  // Tracks whether the last refill went past the transmit threshold.
  always_ff @(posedge clk) begin
    if (rst)                     tx_armed <= 1'b0;
    else if (tx_level > tx_trig) tx_armed <= 1'b1;
    else if (tx_level == '0)     tx_armed <= 1'b0;
  end

  assign tx_irq = tx_armed ? (tx_level < tx_trig) : (tx_level == '0);
  assign rx_irq = (rx_level >= rx_trig);

endmodule

// File: rtl/uft_chk.sv
module uft_chk #(
  parameter int DEPTH = 64,
  parameter int LW    = 7
) (
  input logic          clk,
  input logic          rst,
  input logic          reg_addr,
  input logic [7:0]    reg_rdata,
  input logic [LW-1:0] rx_level,
  input logic [LW-1:0] tx_level,
  input logic          rx_ovr,
  input logic          rx_irq,
  input logic          tx_irq,
  input logic          rx_flush,
  input logic          fifo_en
);

  // R2
  rst_bits_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !reg_addr |-> reg_rdata[2:1] == 2'b00);

  // R3
  rx_flush_empties_chk: assert property (@(posedge clk) disable iff (rst)
    rx_flush |=> rx_level == '0);

  // R6
  rx_step_chk: assert property (@(posedge clk) disable iff (rst)
    !rx_flush |=> (rx_level == $past(rx_level)) ||
                  (rx_level == $past(rx_level) + 1'b1) ||
                  (rx_level + 1'b1 == $past(rx_level)));

  // R7
  rx_no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    rx_level <= LW'(DEPTH));

  // R7
  tx_no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    tx_level <= LW'(DEPTH));

  // R7
  rx_ovr_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_ovr && !rx_flush) |=> rx_ovr);

  // R8
  single_slot_chk: assert property (@(posedge clk) disable iff (rst)
    !fifo_en |-> (rx_level <= LW'(1)) && (tx_level <= LW'(1)));

  // R12
  rx_irq_empty_chk: assert property (@(posedge clk) disable iff (rst)
    rx_level == '0 |-> !rx_irq);

  // R13
  tx_irq_empty_chk: assert property (@(posedge clk) disable iff (rst)
    tx_level == '0 |-> tx_irq);

endmodule

bind uart_fifo_trig_ctrl uft_chk #(.DEPTH(DEPTH), .LW(LW)) u_chk (
  .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
  .rx_level(rx_level), .tx_level(tx_level), .rx_ovr(rx_ovr),
  .rx_irq(rx_irq), .tx_irq(tx_irq), .rx_flush(rx_flush), .fifo_en(fifo_en)
);

// File: tb/sim_uart_fifo_trig_ctrl.sv
module sim_uart_fifo_trig_ctrl;
  localparam int DEPTH = 64;
  localparam int DW    = 8;
  localparam int LW    = 7;

  logic clk = 1'b0, rst = 1'b1;
  logic reg_wr = 1'b0, reg_addr = 1'b0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic [LW-1:0] rx_prog_lvl = '0, tx_prog_lvl = '0;
  logic tx_push = 1'b0, tx_pop = 1'b0, rx_push = 1'b0, rx_pop = 1'b0;
  logic [DW-1:0] tx_wdata = '0, rx_wdata = '0, tx_rdata, rx_rdata;
  logic [LW-1:0] tx_level, rx_level;
  logic tx_ovr, rx_ovr, tx_irq, rx_irq;

  uart_fifo_trig_ctrl #(.DEPTH(DEPTH), .DW(DW)) u0 (.*);

  always #2 clk = ~clk;

  int checks = 0, fails = 0;
  logic [7:0] rxq[$], txq[$];
  logic [7:0] rx_last = '0, tx_last = '0;
  bit m_en = 1'b0;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(logic a, logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = 1'b0;
    if (!a) begin
      if (d[0] != m_en) begin rxq.delete(); txq.delete(); end
      if (d[0] && d[1]) rxq.delete();
      if (d[0] && d[2]) txq.delete();
      m_en = d[0];
    end
  endtask

  task automatic rx_put(logic [7:0] d);
    rx_push = 1'b1; rx_wdata = d;
    @(negedge clk);
    rx_push = 1'b0;
    if (rxq.size() < (m_en ? DEPTH : 1)) rxq.push_back(d);
  endtask

  task automatic tx_put(logic [7:0] d);
    tx_push = 1'b1; tx_wdata = d;
    @(negedge clk);
    tx_push = 1'b0;
    if (txq.size() < (m_en ? DEPTH : 1)) txq.push_back(d);
  endtask

  // Monitor side of the scoreboard: compare each popped byte with the queue head.
  task automatic rx_take(string tag);
    rx_pop = 1'b1;
    @(negedge clk);
    rx_pop = 1'b0;
    if (rxq.size() > 0) rx_last = rxq.pop_front();
    chk(tag, rx_rdata, rx_last);
  endtask

  task automatic tx_take(string tag);
    tx_pop = 1'b1;
    @(negedge clk);
    tx_pop = 1'b0;
    if (txq.size() > 0) tx_last = txq.pop_front();
    chk(tag, tx_rdata, tx_last);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 fcr", reg_rdata, 0);
    chk("R1 tx_level", tx_level, 0);
    chk("R1 rx_level", rx_level, 0);
    chk("R1 tx_irq", tx_irq, 1);
    chk("R1 rx_irq", rx_irq, 0);
    reg_addr = 1'b1; #1;
    chk("R1 tbl", reg_rdata, 0);
    reg_addr = 1'b0;
    @(negedge clk);

    // R8 single slot mode, R7 dropped push
    tx_put(8'hA1);
    chk("R8 tx_level one", tx_level, 1);
    chk("R13 tx_irq unarmed nonempty", tx_irq, 0);
    tx_put(8'hA2);
    chk("R8 tx_level capped", tx_level, 1);
    chk("R7 tx_ovr set", tx_ovr, 1);
    tx_take("R8 tx data");
    chk("R13 tx_irq empty", tx_irq, 1);
    rx_put(8'h5A);
    chk("R12 R8 rx_irq trig one", rx_irq, 1);
    wr(1'b0, 8'hC2);
    chk("R3 gated flush ignored", rx_level, 1);
    chk("R2 gated bits kept", reg_rdata, 0);
    chk("R7 tx_ovr sticky", tx_ovr, 1);

    // R5 enable change flushes both
    wr(1'b0, 8'hC9);
    chk("R5 rx flushed", rx_level, 0);
    chk("R5 tx_ovr cleared", tx_ovr, 0);
    chk("R2 readback", reg_rdata, 8'hC9);

    // R9 table 0 code 3 -> 14
    for (int i = 0; i < 13; i++) rx_put(8'(i + 1));
    chk("R9 R12 below trig", rx_irq, 0);
    rx_put(8'd14);
    chk("R9 R12 at trig", rx_irq, 1);
    rx_take("R6 rx order");
    chk("R12 rx_irq drop", rx_irq, 0);

    // R3 / R4 flush each side only
    for (int i = 0; i < 3; i++) tx_put(8'(8'h70 + i));
    wr(1'b0, 8'hCB);
    chk("R3 rx flushed", rx_level, 0);
    chk("R3 tx untouched", tx_level, 3);
    chk("R2 self clear", reg_rdata, 8'hC9);
    rx_put(8'h11); rx_put(8'h12);
    wr(1'b0, 8'hCD);
    chk("R4 tx flushed", tx_level, 0);
    chk("R4 rx untouched", rx_level, 2);
    wr(1'b0, 8'hCB);

    // R6 / R7 full depth
    for (int i = 0; i < DEPTH; i++) rx_put(8'(i * 3 + 7));
    chk("R6 full level", rx_level, DEPTH);
    chk("R7 no ovr yet", rx_ovr, 0);
    rx_put(8'hEE);
    chk("R7 full push dropped", rx_level, DEPTH);
    chk("R7 rx_ovr", rx_ovr, 1);
    for (int i = 0; i < DEPTH; i++) rx_take("R6 drain order");
    rx_take("R7 empty pop data");
    chk("R7 empty pop level", rx_level, 0);

    // R10 / R13 table 1, tx code 1 -> 8
    wr(1'b1, 8'h01);
    wr(1'b0, 8'h19);
    for (int i = 0; i < 9; i++) tx_put(8'(8'h20 + i));
    tx_take("R6 tx order");
    chk("R13 armed at trig", tx_irq, 0);
    tx_take("R6 tx order");
    chk("R10 R13 armed below", tx_irq, 1);
    for (int i = 0; i < 7; i++) tx_take("R6 tx drain");
    chk("R13 empty", tx_irq, 1);
    for (int i = 0; i < 8; i++) tx_put(8'(8'h40 + i));
    chk("R13 at trig", tx_irq, 0);
    tx_take("R6 tx order");
    chk("R13 unarmed below", tx_irq, 0);
    for (int i = 0; i < 7; i++) tx_take("R6 tx drain");
    chk("R13 unarmed empty", tx_irq, 1);

    // R9 table 2, rx code 2 -> 56
    wr(1'b1, 8'h02);
    wr(1'b0, 8'h81);
    for (int i = 0; i < 55; i++) rx_put(8'(i));
    chk("R9 table2 below", rx_irq, 0);
    rx_put(8'h99);
    chk("R9 table2 at", rx_irq, 1);
    wr(1'b0, 8'h83);

    // R11 table 3
    wr(1'b1, 8'h03);
    rx_prog_lvl = 7'd5; tx_prog_lvl = 7'd3;
    for (int i = 0; i < 4; i++) rx_put(8'(i));
    chk("R11 rx below prog", rx_irq, 0);
    rx_put(8'h04);
    chk("R11 rx at prog", rx_irq, 1);
    wr(1'b0, 8'h83);
    rx_prog_lvl = '0;
    rx_put(8'h05);
    chk("R11 zero acts as one", rx_irq, 1);
    wr(1'b0, 8'h83);
    for (int i = 0; i < 4; i++) tx_put(8'(8'h60 + i));
    tx_take("R6 tx order");
    chk("R11 tx at prog", tx_irq, 0);
    tx_take("R6 tx order");
    chk("R11 tx below prog", tx_irq, 1);
    tx_take("R6 tx drain"); tx_take("R6 tx drain");

    // R10 table 0 tx code 3 -> 1
    wr(1'b1, 8'h00);
    wr(1'b0, 8'h31);
    tx_put(8'hB1); tx_put(8'hB2);
    tx_take("R6 tx order");
    chk("R10 table0 tx level one", tx_irq, 0);
    tx_take("R6 tx order");
    chk("R10 table0 empty", tx_irq, 1);

    // R2 / R8 disable keeps codes, single slot
    wr(1'b0, 8'hF0);
    chk("R2 disable keeps bits", reg_rdata, 8'h30);
    rx_put(8'h01); rx_put(8'h02);
    chk("R8 single slot rx", rx_level, 1);
    rx_take("R8 rx data");

    finish_run();
  end

endmodule